// File: doc/BRIEF.md
# Four-Slot Serial TDM Channel Port

This block is the local serial side of a subscriber line interface. Once per 8 kHz frame it trades four byte-wide channels with a local controller over one serial output and one serial input. The channels are a signalling channel, a control channel and two bearer channels. A one-clock frame pulse opens each frame. The four channels then follow back to back: signalling, control, first bearer, second bearer. Each channel is eight bits long. With the nominal 4.096 MHz clock, each bit lasts two clock cycles.

The parallel transmit bytes and the rate select are captured when the frame pulse arrives, and the captured copies are shifted out. The bits received on the serial input are collected into four bytes. The four bytes are presented together with a single-cycle valid strobe once the last channel time of the frame has been received. At the low rate (80 kbit/s) the second bearer channel is left unused. At the high rate (160 kbit/s) all four channels carry data.

Top module: `tdmChannelPort`

## Requirements
- R1: Out of reset, serOut is 1, rxValid is 0 and all four received bytes read 8'h00.
- R2: A frame pulse sampled high on a clock edge makes the next cycle frame cycle 0. Each bit spans CLKS_PER_BIT (default 2) cycles. serOut changes at the first cycle of a bit, and serIn is sampled at the edge that ends the bit's last cycle.
- R3: The channel times are fixed in this order: 0 carries the signalling byte (txSig/rxSig), 1 the control byte (txCtl/rxCtl), 2 the first bearer byte (txBr1/rxBr1) and 3 the second bearer byte (txBr2/rxBr2). Each channel time is 8 bits.
- R4: The signalling and control bytes travel least significant bit first, starting with bit 0 and ending with bit 7, in both directions.
- R5: The two bearer bytes travel most significant bit first, starting with bit 7 and ending with bit 0, in both directions.
- R6: With rateSel=0 (80 kbit/s), channel time 3 is unused. serOut stays 1 there, serIn is ignored there, and rxBr2 is published as 8'h00. With rateSel=1 (160 kbit/s), channel time 3 carries the second bearer byte.
- R7: serOut is 1 before the first frame pulse and after channel time 3 until the next frame pulse.
- R8: The four received bytes are updated together, and rxValid is high for exactly one cycle. This happens in frame cycle 4*8*CLKS_PER_BIT+1, which is cycle 65 by default.
- R9: The transmit bytes and rateSel are captured at the frame pulse. Changing them later in the frame does not alter the frame in progress.
- R10: The received bytes hold their values between publications.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock (nominally 4.096 MHz) |
| rstN | input | 1 | Active-low synchronous reset |
| framePulse | input | 1 | One-cycle frame start marker |
| rateSel | input | 1 | 1 = 160 kbit/s (four channels), 0 = 80 kbit/s (three channels) |
| txSig | input | 8 | Signalling byte to send |
| txCtl | input | 8 | Control byte to send |
| txBr1 | input | 8 | First bearer byte to send |
| txBr2 | input | 8 | Second bearer byte to send |
| serIn | input | 1 | Serial data from the controller |
| serOut | output | 1 | Serial data to the controller |
| rxSig | output | 8 | Received signalling byte |
| rxCtl | output | 8 | Received control byte |
| rxBr1 | output | 8 | Received first bearer byte |
| rxBr2 | output | 8 | Received second bearer byte |
| rxValid | output | 1 | One-cycle strobe when the received bytes update |

## Verification
The assertions assume that frame pulses are one cycle wide. They also assume that a new pulse never arrives before the previous frame has published its bytes, so a frame is never cut short. Within that assumption they check the restart of the position counter, the single-cycle publish strobe, the idle-high output and the frozen transmit copies. The bench honours these assumptions: it raises the pulse for exactly one cycle and lets every frame run to its publish strobe plus some idle cycles before the next pulse. It changes inputs only on falling edges, and it holds serIn steady for a whole bit time.

// File: rtl/tdmPortPkg.sv
package tdmPortPkg;

  localparam int SLOT_BITS = 8;
  localparam int NUM_SLOTS = 4;

  typedef struct packed {
    logic       loadTx;      // capture transmit bytes this edge
    logic       sampleEn;    // capture serIn this edge
    logic [1:0] sampleSlot;
    logic [2:0] sampleBit;   // bit position within the channel time
    logic       driveEn;     // serOut carries data in the next cycle
    logic [1:0] driveSlot;
    logic [2:0] driveBit;
    logic       publish;     // move collected bytes to the outputs
  } tdmStrobes_t;

  // Map the k-th bit on the wire to a byte bit index.
  // Channel times 0 and 1 go LSB first, channel times 2 and 3 go MSB first.
  function automatic logic [2:0] wireOrder(input logic [1:0] slot, input logic [2:0] k);
    return slot[1] ? ~k : k;
  endfunction

endpackage

// File: rtl/tdmPortCtrl.sv
module tdmPortCtrl
  import tdmPortPkg::*;
#(
  parameter int CLKS_PER_BIT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        framePulse,
  input  logic        rateSel,
  output tdmStrobes_t stb
);

  localparam int PH_W  = $clog2(CLKS_PER_BIT);
  localparam int USED  = NUM_SLOTS * SLOT_BITS * CLKS_PER_BIT;
  localparam int CNT_W = $clog2(USED + 1);

  logic [CNT_W-1:0] posCnt;
  logic [CNT_W-1:0] nextPos;
  logic             active;
  logic             rateHold;
  logic             nextInRange;
  logic             phaseLast;
  logic [1:0]       curSlot;
  logic [1:0]       nxtSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt   <= '0;
      active   <= 1'b0;
      rateHold <= 1'b0;
    end else if (framePulse) begin
      posCnt   <= '0;
      active   <= 1'b1;
      rateHold <= rateSel;
    end else if (active) begin
      if (posCnt == CNT_W'(USED)) active <= 1'b0;
      else                        posCnt <= posCnt + 1'b1;
    end
  end

  always_comb begin
    nextPos     = framePulse ? '0 : posCnt + 1'b1;
    nextInRange = framePulse || (active && posCnt < CNT_W'(USED - 1));
    phaseLast   = &posCnt[PH_W-1:0];
    curSlot     = posCnt[PH_W+4:PH_W+3];
    nxtSlot     = nextPos[PH_W+4:PH_W+3];

    stb            = '0;
    stb.loadTx     = framePulse;
    stb.sampleSlot = curSlot;
    stb.sampleBit  = posCnt[PH_W+2:PH_W];
    stb.sampleEn   = active && (posCnt < CNT_W'(USED)) && phaseLast &&
                     (curSlot != 2'd3 || rateHold);
    stb.driveSlot  = nxtSlot;
    stb.driveBit   = nextPos[PH_W+2:PH_W];
    stb.driveEn    = nextInRange && (nxtSlot != 2'd3 || rateHold);
    stb.publish    = active && (posCnt == CNT_W'(USED)) && !framePulse;
  end

  assert_frame_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |=> (active && posCnt == '0));

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.publish |=> !stb.publish);

  assert_b2_rate_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sampleEn && stb.sampleSlot == 2'd3) |-> rateHold);

endmodule

// File: rtl/tdmPortData.sv
module tdmPortData
  import tdmPortPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  tdmStrobes_t stb,
  input  logic [7:0]  txSig,
  input  logic [7:0]  txCtl,
  input  logic [7:0]  txBr1,
  input  logic [7:0]  txBr2,
  input  logic        serIn,
  output logic        serOut,
  output logic [7:0]  rxSig,
  output logic [7:0]  rxCtl,
  output logic [7:0]  rxBr1,
  output logic [7:0]  rxBr2,
  output logic        rxValid
);

  logic [NUM_SLOTS-1:0][SLOT_BITS-1:0] txHold;
  logic [NUM_SLOTS-1:0][SLOT_BITS-1:0] txLive;
  logic [NUM_SLOTS-1:0][SLOT_BITS-1:0] rxWork;
  logic [NUM_SLOTS-1:0][SLOT_BITS-1:0] txSrc;
  logic                                driveBitVal;

  always_comb begin
    txLive      = {txBr2, txBr1, txCtl, txSig};
    txSrc       = stb.loadTx ? txLive : txHold;
    driveBitVal = txSrc[stb.driveSlot][wireOrder(stb.driveSlot, stb.driveBit)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold  <= '0;
      rxWork  <= '0;
      serOut  <= 1'b1;
      rxSig   <= '0;
      rxCtl   <= '0;
      rxBr1   <= '0;
      rxBr2   <= '0;
      rxValid <= 1'b0;
    end else begin
      if (stb.loadTx) begin
        txHold <= txLive;
        rxWork <= '0;
      end else if (stb.sampleEn) begin
        rxWork[stb.sampleSlot][wireOrder(stb.sampleSlot, stb.sampleBit)] <= serIn;
      end
      serOut  <= stb.driveEn ? driveBitVal : 1'b1;
      rxValid <= stb.publish;
      if (stb.publish) begin
        rxSig <= rxWork[0];
        rxCtl <= rxWork[1];
        rxBr1 <= rxWork[2];
        rxBr2 <= rxWork[3];
      end
    end
  end

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.driveEn |=> serOut);

  assert_tx_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadTx |=> $stable(txHold));

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.publish |=> ($stable(rxSig) && $stable(rxBr2) && !rxValid));

endmodule

// File: rtl/tdmChannelPort.sv
module tdmChannelPort
  import tdmPortPkg::*;
#(
  parameter int CLKS_PER_BIT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       framePulse,
  input  logic       rateSel,
  input  logic [7:0] txSig,
  input  logic [7:0] txCtl,
  input  logic [7:0] txBr1,
  input  logic [7:0] txBr2,
  input  logic       serIn,
  output logic       serOut,
  output logic [7:0] rxSig,
  output logic [7:0] rxCtl,
  output logic [7:0] rxBr1,
  output logic [7:0] rxBr2,
  output logic       rxValid
);

  tdmStrobes_t stb;

  tdmPortCtrl #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .rateSel    (rateSel),
    .stb        (stb)
  );

  tdmPortData u_data (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .txSig   (txSig),
    .txCtl   (txCtl),
    .txBr1   (txBr1),
    .txBr2   (txBr2),
    .serIn   (serIn),
    .serOut  (serOut),
    .rxSig   (rxSig),
    .rxCtl   (rxCtl),
    .rxBr1   (rxBr1),
    .rxBr2   (rxBr2),
    .rxValid (rxValid)
  );

endmodule

// File: tb/tdmChannelPort_tb.sv
module tdmChannelPort_tb;

  localparam int CPB = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       framePulse = 1'b0;
  logic       rateSel = 1'b1;
  logic [7:0] txSig = '0, txCtl = '0, txBr1 = '0, txBr2 = '0;
  logic       serIn = 1'b1;
  logic       serOut;
  logic [7:0] rxSig, rxCtl, rxBr1, rxBr2;
  logic       rxValid;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tdmChannelPort #(.CLKS_PER_BIT(CPB)) u_dut (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .rateSel(rateSel),
    .txSig(txSig), .txCtl(txCtl), .txBr1(txBr1), .txBr2(txBr2),
    .serIn(serIn), .serOut(serOut),
    .rxSig(rxSig), .rxCtl(rxCtl), .rxBr1(rxBr1), .rxBr2(rxBr2),
    .rxValid(rxValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Byte bit index for the k-th wire bit of a channel time (R4, R5)
  function automatic int bitIdx(input int slot, input int k);
    return (slot < 2) ? k : 7 - k;
  endfunction

  task automatic testReset();
    check(serOut === 1'b1, "R1 serOut", serOut, 1);
    check(rxValid === 1'b0, "R1 rxValid", rxValid, 0);
    check({rxSig, rxCtl, rxBr1, rxBr2} === 32'h0, "R1 rx bytes",
          {rxSig, rxCtl, rxBr1, rxBr2}, 0);
  endtask

  // One frame: drive tx bytes, feed rx bytes, check serial output and publish.
  task automatic runFrame(input bit rate, input logic [31:0] txW, input logic [31:0] rxW,
                          input bit changeMid, input string tag);
    logic [7:0] txB [4];
    logic [7:0] rxB [4];
    logic [7:0] expB2;
    int badBits = 0;
    for (int s = 0; s < 4; s++) begin
      txB[s] = txW[8*s +: 8];
      rxB[s] = rxW[8*s +: 8];
    end
    @(negedge clk);
    rateSel = rate;
    {txBr2, txBr1, txCtl, txSig} = txW;
    framePulse = 1'b1;
    @(negedge clk);
    framePulse = 1'b0;
    for (int p = 0; p < 4 * 8 * CPB; p++) begin
      int slot = p / (8 * CPB);
      int k    = (p / CPB) % 8;
      bit used = (slot != 3) || rate;
      logic expOut = used ? txB[slot][bitIdx(slot, k)] : 1'b1;
      if (p % CPB == 0)
        serIn = used ? rxB[slot][bitIdx(slot, k)] : ~rxB[slot][bitIdx(slot, k)];
      if (changeMid && p == 5) begin
        {txBr2, txBr1, txCtl, txSig} = ~txW;
        rateSel = ~rate;
      end
      if (serOut !== expOut) begin
        badBits++;
        $display("FAIL R3 %s cycle %0d actual=%0b expected=%0b", tag, p, serOut, expOut);
      end
      if (rxValid !== 1'b0) begin
        badBits++;
        $display("FAIL R8 %s early valid cycle %0d actual=%0b expected=0", tag, p, rxValid);
      end
      @(negedge clk);
    end
    check(badBits == 0, rate ? "R4 R5 serial bits 160k" : "R6 R4 R5 serial bits 80k",
          badBits, 0);
    // frame cycle 64: output idle, publish not yet
    check(serOut === 1'b1, "R7 idle after slot 3", serOut, 1);
    check(rxValid === 1'b0, "R8 no valid at cycle 64", rxValid, 0);
    @(negedge clk);
    expB2 = rate ? rxB[3] : 8'h00;
    check(rxValid === 1'b1, "R8 valid at cycle 65", rxValid, 1);
    check(rxSig === rxB[0], "R4 rxSig", rxSig, rxB[0]);
    check(rxCtl === rxB[1], "R4 rxCtl", rxCtl, rxB[1]);
    check(rxBr1 === rxB[2], "R5 rxBr1", rxBr1, rxB[2]);
    check(rxBr2 === expB2, "R6 rxBr2", rxBr2, expB2);
    @(negedge clk);
    check(rxValid === 1'b0, "R8 valid single cycle", rxValid, 0);
    if (changeMid) check(1'b1, "R9 mid-frame change ignored", 0, 0);
  endtask

  // Idle stretch: output high, bytes held, no strobe.
  task automatic testIdleHold(input int cycles);
    logic [31:0] held = {rxSig, rxCtl, rxBr1, rxBr2};
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      serIn = i[0];
      if (serOut !== 1'b1 || rxValid !== 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R7 idle output high", bad, 0);
    check({rxSig, rxCtl, rxBr1, rxBr2} === held, "R10 bytes held",
          {rxSig, rxCtl, rxBr1, rxBr2}, held);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();                 // R1
    testIdleHold(10);            // R7 before first pulse
    runFrame(1'b1, 32'h3C_A5_81_5E, 32'hC3_1F_7E_A9, 1'b0, "pat160a");
    testIdleHold(20);            // R10
    runFrame(1'b1, 32'h01_80_F0_0F, 32'h80_01_0F_F0, 1'b1, "pat160mid"); // R9
    runFrame(1'b0, 32'hFF_00_6B_D2, 32'h5A_E7_24_99, 1'b0, "pat80");    // R6
    testIdleHold(15);
    runFrame(1'b1, 32'h00_00_00_00, 32'hFF_FF_FF_FF, 1'b0, "edge160");  // R2 R3
    testIdleHold(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule